// File: doc/BRIEF.md
# Periodic Tick Timer

A register-mapped down-counter that produces a steady time base for system software. Software loads a reload value, starts the counter and then either polls a sticky status flag or takes a one-cycle interrupt request each time the count reaches zero. The counter then reloads and starts the next period. The counter advances once per cycle of the core clock, or once per rising edge of a slower external tick. That external tick is brought into the core clock domain inside the block.

Access is through a simple single-cycle register port with an address, a write strobe, write data, a read strobe and read data. Read data is valid combinationally in the same cycle as the read strobe. Reading the status register clears the sticky flag as a side effect. Writing any value to the current-value register restarts the period. A read-only calibration word, supplied on a constant input, reports the nominal count for a ten-millisecond interval.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status (offset 0x010), reload (0x014) and current-value (0x018) registers read 0, and the interrupt request is low.
- R2: The current-value register reads the count held in the cycle of the read. While control bit 0 (enable) is 1, the count drops by one on each active tick. While enable is 0, the count holds.
- R3: When the count is 0, the next active tick loads the reload value (bits 23:0 of 0x014) instead of decrementing, so one period lasts reload+1 ticks.
- R4: Status bit 16 (the flag) becomes 1 when the count steps from 1 to 0. A read of 0x010 returns the flag and then clears it. If that read falls in the same cycle as a step to zero, the flag stays 1. Writes to 0x010 never change the flag.
- R5: A write of any data to 0x018 sets the count to 0 and clears the flag. The next active tick reloads the count. A step to zero that coincides with such a write sets no flag and raises no interrupt.
- R6: When control bit 1 (interrupt enable) is 1, the interrupt request is high for exactly the one cycle in which the count first holds 0 after stepping down from 1.
- R7: Offset 0x01C returns the calibration input with bits 31 (no-reference), 30 (skew) and 23:0 (ten-millisecond count) kept and bits 29:24 forced to 0. Writes to 0x01C are ignored.
- R8: Reserved bits read as 0 and ignore writes. This covers bits 31:17 and 15:3 of 0x010, and bits 31:24 of 0x014 and of 0x018.
- R9: When control bit 2 (clock source) is 1, the active tick is the rising edge of the external tick after a two-flop synchronizer. The count changes on the third core clock edge after the external input rises, and it changes only once per rising edge.
- R10: With a reload value of 0, the count stays at 0 across ticks. In that state the flag is not set again and no interrupt is raised.
- R11: A read of any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd, 0 otherwise |
| ext_tick | input | 1 | Slow external tick, asynchronous, at most 1/2.5 of the core clock rate |
| calib_word | input | 32 | Constant calibration word |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with its defaults: a 24-bit counter, 32-bit data, 12-bit offsets and a two-stage synchronizer. It programs reload values of 4, 2 and 0, so that full periods, reloads and zero crossings happen within a few cycles. This makes it possible to check, cycle by cycle, a status read and a current-value write that each land exactly on a step to zero. Driving the external tick high and low for three cycles each brings the synchronizer latency and the single count per edge within reach.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared register offsets and control-bit positions of the tick timer.
// Assumes byte offsets fit in the top-level address width.
package tick_timer_pkg;
    parameter int unsigned OFF_CTRL  = 'h010;
    parameter int unsigned OFF_RELD  = 'h014;
    parameter int unsigned OFF_CURR  = 'h018;
    parameter int unsigned OFF_CALIB = 'h01C;

    parameter int unsigned BIT_EN    = 0;
    parameter int unsigned BIT_IE    = 1;
    parameter int unsigned BIT_SRC   = 2;
    parameter int unsigned BIT_FLAG  = 16;

    typedef struct packed {
        logic src_ext;
        logic irq_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/tick_sync.sv
`timescale 1ns/1ps
// Module: tick_sync
// Brings an asynchronous slow tick into the core domain through STAGES
// flops, then turns each rising edge into a one-cycle pulse.
// Assumes the input stays high and low for at least two core cycles each.
module tick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int unsigned LAST = STAGES;

    logic [LAST:0] pipe_q;

    // First capture flop of the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= 1'b0;
        else        pipe_q[0] <= async_in;
    end

    for (genvar i = 1; i <= LAST; i++) begin : g_stage
        // Remaining synchronizer flops plus the edge-history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q[i] <= 1'b0;
            else        pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign rise_pulse = pipe_q[LAST-1] & ~pipe_q[LAST];

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/tick_counter.sv
`timescale 1ns/1ps
// Module: tick_counter
// The down-counter: it decrements on each tick, loads the reload value on a
// tick at zero, and is forced to zero by a clear that outranks the tick.
// It flags the tick that steps the count from 1 to 0.
// Assumes tick and clear are single-cycle, synchronous strobes.
module tick_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             at_zero;

    assign at_zero  = (count_q == '0);
    assign hit_zero = tick & ~clr & (count_q == ONE);
    assign count    = count_q;

    // Count register: clear first, then reload at zero, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= '0;
        else if (clr)   count_q <= '0;
        else if (tick)  count_q <= at_zero ? reload : count_q - ONE;
    end

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && count_q != '0) |=> count_q == $past(count_q) - ONE);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(count_q));
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && count_q == '0) |=> count_q == $past(reload));
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count_q == '0);
endmodule

// File: rtl/tick_regs.sv
`timescale 1ns/1ps
// Module: tick_regs
// Register file: decodes the single-cycle register port, holds the control
// bits, the reload value and the sticky flag, forms the read data and
// registers the interrupt pulse.
// Assumes a read strobe and a write strobe do not target the same offset in
// one cycle.
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] calib,
    input  logic [CNT_W-1:0]  count,
    input  logic              hit_zero,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              count_clr,
    output logic              irq
);
    localparam int unsigned PAD_W = DATA_W - CNT_W;
    localparam logic [DATA_W-1:0] CAL_KEEP =
        {2'b11, {(DATA_W-2-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic hit_ctrl, hit_reld, hit_curr, hit_calib;
    logic ctrl_wr, reld_wr, ctrl_rd;
    logic flag_q, irq_q;
    ctrl_t ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic unused_wdata;

    assign hit_ctrl  = (addr == ADDR_W'(OFF_CTRL));
    assign hit_reld  = (addr == ADDR_W'(OFF_RELD));
    assign hit_curr  = (addr == ADDR_W'(OFF_CURR));
    assign hit_calib = (addr == ADDR_W'(OFF_CALIB));

    assign ctrl_wr   = wr & hit_ctrl;
    assign reld_wr   = wr & hit_reld;
    assign count_clr = wr & hit_curr;
    assign ctrl_rd   = rd & hit_ctrl;
    assign unused_wdata = ^wdata;

    // Control bits: loaded only by writes to the control/status offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.run     <= wdata[BIT_EN];
            ctrl_q.irq_en  <= wdata[BIT_IE];
            ctrl_q.src_ext <= wdata[BIT_SRC];
        end
    end

    // Reload value: the low CNT_W bits of a reload write.
    always_ff @(posedge clk) begin
        if (!rst_n)       reload_q <= '0;
        else if (reld_wr) reload_q <= wdata[CNT_W-1:0];
    end

    // Sticky flag: a count clear wins, a new zero wins over a read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (count_clr) flag_q <= 1'b0;
        else if (hit_zero)  flag_q <= 1'b1;
        else if (ctrl_rd)   flag_q <= 1'b0;
    end

    // Interrupt pulse: high in the cycle the count lands on zero.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= hit_zero & ctrl_q.irq_en;
    end

    // Read data: mapped fields for the addressed offset, zero otherwise.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (hit_ctrl) begin
                rdata[BIT_FLAG] = flag_q;
                rdata[BIT_SRC]  = ctrl_q.src_ext;
                rdata[BIT_IE]   = ctrl_q.irq_en;
                rdata[BIT_EN]   = ctrl_q.run;
            end else if (hit_reld) begin
                rdata = {{PAD_W{1'b0}}, reload_q};
            end else if (hit_curr) begin
                rdata = {{PAD_W{1'b0}}, count};
            end else if (hit_calib) begin
                rdata = calib & CAL_KEEP;
            end
        end
    end

    assign ctrl   = ctrl_q;
    assign reload = reload_q;
    assign irq    = irq_q;

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_zero |=> flag_q);
    assert_flag_readclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !hit_zero) |=> !flag_q);
    assert_flag_wrclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count_clr |=> !flag_q);
    assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> rdata == '0);
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
// Module: tick_timer (top)
// Periodic tick timer: the register file, the down-counter and the external
// tick synchronizer. The active tick is the core clock or the synchronized
// external edge, gated by the run bit.
// Assumes ext_tick runs at no more than 1/2.5 of the core clock rate and
// calib_word is static.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W       = 24,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_tick,
    input  logic [DATA_W-1:0] calib_word,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, count;
    logic             count_clr, hit_zero, ext_pulse, tick;

    assign tick = ctrl.run & (ctrl.src_ext ? ext_pulse : 1'b1);

    tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (ext_tick),
        .rise_pulse (ext_pulse)
    );

    tick_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (count_clr),
        .reload   (reload),
        .count    (count),
        .hit_zero (hit_zero)
    );

    tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .rd        (reg_rd),
        .rdata     (reg_rdata),
        .calib     (calib_word),
        .count     (count),
        .hit_zero  (hit_zero),
        .ctrl      (ctrl),
        .reload    (reload),
        .count_clr (count_clr),
        .irq       (irq)
    );

    assert_irq_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> count == '0);
    assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_no_zero_refire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !hit_zero);
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected data and interrupt level into a
// queue; a monitor at the falling edge pops and compares them.
module tick_timer_tb;
    localparam logic [11:0] A_CTRL = 12'h010;
    localparam logic [11:0] A_RELD = 12'h014;
    localparam logic [11:0] A_CURR = 12'h018;
    localparam logic [11:0] A_CAL  = 12'h01C;
    localparam logic [31:0] CAL_IN = 32'hFF12_3456;
    localparam logic [31:0] CAL_EX = 32'hC012_3456;

    typedef struct {
        logic [31:0] data;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        ext_tick = 1'b0;
    logic        irq;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    tick_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .ext_tick   (ext_tick),
        .calib_word (CAL_IN),
        .irq        (irq)
    );

    // Driver: one write, occupying one cycle.
    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    // Driver: one read with its expectation pushed to the scoreboard.
    task automatic rd_chk(input logic [11:0] a, input logic [31:0] d,
                          input logic ei, input string tag);
        exp_t e;
        e.data = d; e.irq = ei; e.tag = tag;
        sb.push_back(e);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // Monitor: compare read data and interrupt mid-cycle during each read.
    always @(negedge clk) begin
        if (rst_n && reg_rd && !finished) begin
            exp_t e;
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: rdata=%h", reg_rdata);
            end else begin
                e = sb.pop_front();
                if (reg_rdata !== e.data || irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, reg_rdata, irq, e.data, e.irq);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (3000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state; R7 calibration masking
        rd_chk(A_CTRL, 32'h0, 1'b0, "R1 ctrl reset");
        rd_chk(A_RELD, 32'h0, 1'b0, "R1 reload reset");
        rd_chk(A_CURR, 32'h0, 1'b0, "R1 count reset");
        rd_chk(A_CAL,  CAL_EX, 1'b0, "R7 calib read");

        // R8 upper reload bits dropped; R2/R3 free-running period of 5
        wr_reg(A_RELD, 32'hFF00_0004);
        rd_chk(A_RELD, 32'h4, 1'b0, "R8 reload upper bits");
        wr_reg(A_CURR, 32'h123);
        wr_reg(A_CTRL, 32'h1);
        rd_chk(A_CURR, 32'h0, 1'b0, "R2 count before first tick");
        rd_chk(A_CURR, 32'h4, 1'b0, "R3 reload at zero");
        rd_chk(A_CURR, 32'h3, 1'b0, "R2 decrement");
        rd_chk(A_CURR, 32'h2, 1'b0, "R2 decrement");
        rd_chk(A_CURR, 32'h1, 1'b0, "R2 decrement");
        rd_chk(A_CURR, 32'h0, 1'b0, "R2 reached zero, no irq when disabled");
        rd_chk(A_CURR, 32'h4, 1'b0, "R3 period reload+1");
        rd_chk(A_CTRL, 32'h0001_0001, 1'b0, "R4 flag set");
        rd_chk(A_CTRL, 32'h0000_0001, 1'b0, "R4 flag cleared by read");
        rd_chk(A_CURR, 32'h1, 1'b0, "R2 count");
        rd_chk(A_CURR, 32'h0, 1'b0, "R2 count zero");
        wr_reg(A_CTRL, 32'h0);
        rd_chk(A_CURR, 32'h3, 1'b0, "R2 last tick before stop");
        rd_chk(A_CURR, 32'h3, 1'b0, "R2 hold when disabled");
        rd_chk(A_CTRL, 32'h0001_0000, 1'b0, "R4 flag kept while stopped");
        rd_chk(A_CTRL, 32'h0, 1'b0, "R4 flag read-cleared");

        // R5 current-value write clears count and flag mid-period
        wr_reg(A_CTRL, 32'h1);
        rd_chk(A_CURR, 32'h3, 1'b0, "R2 resume");
        rd_chk(A_CURR, 32'h2, 1'b0, "R2 decrement");
        rd_chk(A_CURR, 32'h1, 1'b0, "R2 decrement");
        rd_chk(A_CURR, 32'h0, 1'b0, "R2 zero");
        wr_reg(A_CURR, 32'hABC);
        rd_chk(A_CURR, 32'h0, 1'b0, "R5 count cleared by write");
        rd_chk(A_CTRL, 32'h1, 1'b0, "R5 flag cleared by write");
        rd_chk(A_CURR, 32'h3, 1'b0, "R5 reload after clear");

        // R6 interrupt pulse; R4 read coinciding with zero step
        wr_reg(A_CTRL, 32'h3);
        rd_chk(A_CURR, 32'h1, 1'b0, "R6 irq low before zero");
        rd_chk(A_CURR, 32'h0, 1'b1, "R6 irq at zero");
        rd_chk(A_CURR, 32'h4, 1'b0, "R6 irq one cycle");
        rd_chk(A_CURR, 32'h3, 1'b0, "R2 decrement");
        rd_chk(A_CURR, 32'h2, 1'b0, "R2 decrement");
        rd_chk(A_CTRL, 32'h0001_0003, 1'b0, "R4 read while stepping to zero");
        rd_chk(A_CTRL, 32'h0001_0003, 1'b1, "R4 flag survives same-cycle read");
        rd_chk(A_CTRL, 32'h0000_0003, 1'b0, "R4 flag cleared");

        // R5 current-value write on the zero step
        rd_chk(A_CURR, 32'h3, 1'b0, "R2 decrement");
        rd_chk(A_CURR, 32'h2, 1'b0, "R2 decrement");
        wr_reg(A_CURR, 32'h0);
        rd_chk(A_CTRL, 32'h3, 1'b0, "R5 no flag or irq on coinciding write");
        rd_chk(A_CURR, 32'h4, 1'b0, "R5 reload after clear");

        // R10 zero reload
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_RELD, 32'h0);
        wr_reg(A_CURR, 32'h0);
        rd_chk(A_CTRL, 32'h0, 1'b0, "R10 flag clear before run");
        wr_reg(A_CTRL, 32'h3);
        rd_chk(A_CURR, 32'h0, 1'b0, "R10 stays zero");
        rd_chk(A_CURR, 32'h0, 1'b0, "R10 stays zero, no irq");
        rd_chk(A_CURR, 32'h0, 1'b0, "R10 stays zero, no irq");
        rd_chk(A_CTRL, 32'h3, 1'b0, "R10 no flag");

        // R8 reserved bits; R7 read-only calib; R11 unmapped read
        wr_reg(A_CTRL, 32'hFFFF_FFF8);
        rd_chk(A_CTRL, 32'h0, 1'b0, "R8 reserved and flag bits ignore write");
        wr_reg(A_CAL, 32'h0);
        rd_chk(A_CAL, CAL_EX, 1'b0, "R7 calib write ignored");
        rd_chk(12'h020, 32'h0, 1'b0, "R11 unmapped offset");
        wr_reg(A_RELD, 32'hAB00_0002);
        rd_chk(A_RELD, 32'h2, 1'b0, "R8 reload upper bits");

        // R9 external tick source
        wr_reg(A_CURR, 32'h0);
        wr_reg(A_CTRL, 32'h5);
        rd_chk(A_CURR, 32'h0, 1'b0, "R9 no count without external edge");
        ext_tick = 1'b1;
        rd_chk(A_CURR, 32'h0, 1'b0, "R9 sync stage 1");
        rd_chk(A_CURR, 32'h0, 1'b0, "R9 sync stage 2");
        rd_chk(A_CURR, 32'h0, 1'b0, "R9 pulse cycle");
        ext_tick = 1'b0;
        rd_chk(A_CURR, 32'h2, 1'b0, "R9 reload on third edge");
        rd_chk(A_CURR, 32'h2, 1'b0, "R9 single count per edge");
        rd_chk(A_CURR, 32'h2, 1'b0, "R9 held while low");
        ext_tick = 1'b1;
        rd_chk(A_CURR, 32'h2, 1'b0, "R9 held");
        rd_chk(A_CURR, 32'h2, 1'b0, "R9 held");
        rd_chk(A_CURR, 32'h2, 1'b0, "R9 held");
        ext_tick = 1'b0;
        rd_chk(A_CURR, 32'h1, 1'b0, "R9 decrement on external edge");

        @(posedge clk); #1;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            if (sb.size() != 0) begin
                n_fail++;
                $display("FAIL scoreboard: %0d left, expected 0", sb.size());
            end
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule